// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits on the bus side of a small processor and keeps the instruction stream ahead of the execution side. While the shared memory port has nothing better to do, it reads code bytes one at a time and stores them in a six-entry first-in first-out queue. The execution side drains that queue through a valid/ready handshake. Each code byte is read at a 20-bit physical address formed from a 16-bit code segment and a 16-bit instruction offset.

The execution side can also ask for its own byte transfer to memory or to I/O. Such a data transfer always wins the memory port the next time the port is free. A fetch that is already in flight is never cut short. When the execution side jumps, it pulses a flush with the new segment and offset. The flush empties the queue, throws away any code byte still on its way, and restarts fetching from the new address.

The memory port carries one transfer at a time. A request holds its address and controls steady until the memory answers with a one-cycle acknowledge.

Top module: `ifq_prefetch`

## Requirements
- R1: While `rst` is high, `mem_req_o` and `out_valid_o` are 0. Segment and offset reset to 0. In the first cycle after reset is released, the block raises a fetch (`mem_we_o`=0, `mem_io_o`=0) at address 0x00000.
- R2: The fetch address is (segment × 16 + offset) modulo 2^20. For example, segment 0xFFFF with offset 0x0020 gives 0x00010.
- R3: The offset steps by one for every fetch issued. It wraps from 0xFFFF to 0x0000 and leaves the segment unchanged.
- R4: Queued bytes plus a fetch in flight never exceed 6. With no byte taken, exactly six fetches complete after reset, and the port then stays idle. Each byte taken allows one more fetch.
- R5: Bytes leave on `out_byte_o` in the order they were fetched. A byte is taken at a rising edge where `out_valid_o` and `out_ready_i` are both 1.
- R6: At most one transfer is outstanding. While `mem_req_o` is 1 and `mem_ack_i` is 0, the address, `mem_we_o`, `mem_io_o` and `mem_wdata_o` hold steady. A transfer completes at the edge where `mem_ack_i` is 1.
- R7: A pending data request takes the port ahead of a fetch whenever the port is free. A fetch in flight finishes first. From an idle port, the data transfer appears in the cycle after `dreq_valid_i` is first sampled.
- R8: When a data transfer is acknowledged and the queue has room, a fetch at the next code address is on the port in the following cycle.
- R9: A flush pulse empties the queue by the next cycle. It also discards the result of any fetch in flight and loads the new segment and offset. No fetch is issued in the flush cycle. A handshake in that cycle is ignored. The first byte delivered afterwards comes from the new address.
- R10: `dreq_done_o` is 1 in the cycle the data transfer is acknowledged, and `dreq_rdata_o` then carries the memory's data. The write flag, I/O flag, address and write data reach the port unchanged. The requester holds `dreq_valid_i` through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | One-cycle pulse: restart fetching at a new code address |
| flush_seg_i | input | 16 | Code segment loaded on flush |
| flush_off_i | input | 16 | Instruction offset loaded on flush |
| out_valid_o | output | 1 | Queue holds at least one byte |
| out_byte_o | output | 8 | Oldest queued byte |
| out_ready_i | input | 1 | Consumer takes the byte at this edge |
| dreq_valid_i | input | 1 | Execution side requests a data transfer |
| dreq_write_i | input | 1 | 1 = write, 0 = read |
| dreq_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| dreq_addr_i | input | 20 | Data transfer address |
| dreq_wdata_i | input | 8 | Data transfer write byte |
| dreq_done_o | output | 1 | Data transfer acknowledged this cycle |
| dreq_rdata_o | output | 8 | Read byte, valid with dreq_done_o |
| mem_req_o | output | 1 | Transfer on the memory port |
| mem_addr_o | output | 20 | Transfer address |
| mem_we_o | output | 1 | Transfer is a write |
| mem_io_o | output | 1 | Transfer targets I/O space |
| mem_wdata_o | output | 8 | Write byte |
| mem_ack_i | input | 1 | Memory completes the transfer this cycle |
| mem_rdata_i | input | 8 | Read byte, valid with mem_ack_i |

## Verification
Two collisions matter here.

The first is a data request that arrives while a fetch is waiting on a slow memory. The bench raises the request just after the fetch appears, with a three-cycle acknowledge latency. It then checks three things: the memory served the fetch address before the data address, the read byte came back with done, and the very next cycle showed a fetch at the following offset.

The second is a flush that lands while a fetch is still outstanding. The bench starts a fetch with a six-cycle latency and flushes to another segment before it is acknowledged. Every byte delivered afterwards must match the new address sequence, so a stale byte that slipped into the queue would show up as a miscompare.

// File: rtl/ifq_pkg.sv
`timescale 1ns/1ps
package ifq_pkg;
  // Who currently owns the shared memory port.
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_DATA  = 2'd2
  } bus_owner_e;
endpackage

// File: rtl/ifq_ptr.sv
`timescale 1ns/1ps
// Code segment / instruction offset pair and physical address former.
module ifq_ptr #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  logic [SEG_W-1:0]  seg_q;
  logic [OFF_W-1:0]  off_q;
  logic [ADDR_W-1:0] base_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      off_q <= '0;
    end else if (load_i) begin
      seg_q <= seg_i;
      off_q <= off_i;
    end else if (step_i) begin
      off_q <= off_q + 1'b1;  // wraps inside the segment
    end
  end

  assign base_w       = ADDR_W'(seg_q) << SHIFT;
  assign fetch_addr_o = base_w + ADDR_W'(off_q);
endmodule

// File: rtl/ifq_store.sv
`timescale 1ns/1ps
// Circular byte queue; storage array has no reset so it maps onto RAM.
module ifq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              rdy_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] dout_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] ram [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pop_w, put_w;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign put_w = push_i && !clr_i;
  assign pop_w = valid_o && rdy_i && !clr_i;

  always_ff @(posedge clk) begin
    if (put_w) ram[wr_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (put_w) wr_q <= bump(wr_q);
      if (pop_w) rd_q <= bump(rd_q);
      case ({put_w, pop_w})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign valid_o = (cnt_q != '0);
  assign dout_o  = ram[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/ifq_busarb.sv
`timescale 1ns/1ps
// Memory port owner: data transfers first, fetches in the background.
module ifq_busarb
  import ifq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic              room_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              dreq_valid_i,
  input  logic              dreq_write_i,
  input  logic              dreq_io_i,
  input  logic [ADDR_W-1:0] dreq_addr_i,
  input  logic [DATA_W-1:0] dreq_wdata_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_io_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              fetch_issue_o,
  output logic              fetch_land_o,
  output logic              data_done_o
);
  bus_owner_e own_q, own_d;
  logic       drop_q;
  logic       ack_fetch, ack_data, bus_free, take_data, take_fetch;

  always_comb begin
    ack_fetch  = mem_ack_i && (own_q == BUS_FETCH);
    ack_data   = mem_ack_i && (own_q == BUS_DATA);
    bus_free   = (own_q == BUS_IDLE) || mem_ack_i;
    // a request still shown during its own acknowledge is the one finishing
    take_data  = bus_free && dreq_valid_i && (own_q != BUS_DATA);
    take_fetch = bus_free && !take_data && room_i && !flush_i;
    own_d      = own_q;
    if (bus_free) begin
      if (take_data)       own_d = BUS_DATA;
      else if (take_fetch) own_d = BUS_FETCH;
      else                 own_d = BUS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q       <= BUS_IDLE;
      mem_req_o   <= 1'b0;
      mem_addr_o  <= '0;
      mem_we_o    <= 1'b0;
      mem_io_o    <= 1'b0;
      mem_wdata_o <= '0;
      drop_q      <= 1'b0;
    end else begin
      own_q     <= own_d;
      mem_req_o <= (own_d != BUS_IDLE);
      if (take_data) begin
        mem_addr_o  <= dreq_addr_i;
        mem_we_o    <= dreq_write_i;
        mem_io_o    <= dreq_io_i;
        mem_wdata_o <= dreq_wdata_i;
      end else if (take_fetch) begin
        mem_addr_o  <= fetch_addr_i;
        mem_we_o    <= 1'b0;
        mem_io_o    <= 1'b0;
        mem_wdata_o <= '0;
      end
      if (ack_fetch)                            drop_q <= 1'b0;
      else if (flush_i && own_q == BUS_FETCH)   drop_q <= 1'b1;
    end
  end

  assign fetch_issue_o = take_fetch;
  assign fetch_land_o  = ack_fetch && !drop_q && !flush_i;
  assign data_done_o   = ack_data;
endmodule

// File: rtl/ifq_prefetch.sv
`timescale 1ns/1ps
module ifq_prefetch #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic [SEG_W-1:0]  flush_seg_i,
  input  logic [OFF_W-1:0]  flush_off_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_byte_o,
  input  logic              out_ready_i,
  input  logic              dreq_valid_i,
  input  logic              dreq_write_i,
  input  logic              dreq_io_i,
  input  logic [ADDR_W-1:0] dreq_addr_i,
  input  logic [DATA_W-1:0] dreq_wdata_i,
  output logic              dreq_done_o,
  output logic [DATA_W-1:0] dreq_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_io_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [ADDR_W-1:0] fetch_addr;
  logic              fetch_issue, fetch_land, room;
  logic [CNT_W-1:0]  q_count;
  logic [CNT_W:0]    occ_nx;
  logic              pop_w;

  // occupancy after this edge decides whether another fetch fits
  assign pop_w  = out_valid_o && out_ready_i && !flush_i;
  assign occ_nx = {1'b0, q_count} + (CNT_W+1)'(fetch_land) - (CNT_W+1)'(pop_w);
  assign room   = occ_nx < (CNT_W+1)'(DEPTH);

  ifq_ptr #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .SHIFT(SHIFT)
  ) u_ptr (
    .clk          (clk),
    .rst          (rst),
    .load_i       (flush_i),
    .seg_i        (flush_seg_i),
    .off_i        (flush_off_i),
    .step_i       (fetch_issue),
    .fetch_addr_o (fetch_addr)
  );

  ifq_busarb #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_arb (
    .clk           (clk),
    .rst           (rst),
    .flush_i       (flush_i),
    .room_i        (room),
    .fetch_addr_i  (fetch_addr),
    .dreq_valid_i  (dreq_valid_i),
    .dreq_write_i  (dreq_write_i),
    .dreq_io_i     (dreq_io_i),
    .dreq_addr_i   (dreq_addr_i),
    .dreq_wdata_i  (dreq_wdata_i),
    .mem_ack_i     (mem_ack_i),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_we_o      (mem_we_o),
    .mem_io_o      (mem_io_o),
    .mem_wdata_o   (mem_wdata_o),
    .fetch_issue_o (fetch_issue),
    .fetch_land_o  (fetch_land),
    .data_done_o   (dreq_done_o)
  );

  ifq_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (flush_i),
    .push_i  (fetch_land),
    .din_i   (mem_rdata_i),
    .rdy_i   (out_ready_i),
    .valid_o (out_valid_o),
    .dout_o  (out_byte_o),
    .count_o (q_count)
  );

  assign dreq_rdata_o = mem_rdata_i;
endmodule

// File: rtl/ifq_chk.sv
`timescale 1ns/1ps
module ifq_chk #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 3,
  parameter int DEPTH  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              flush_i,
  input logic              out_valid_o,
  input logic              dreq_valid_i,
  input logic [ADDR_W-1:0] dreq_addr_i,
  input logic              dreq_done_o,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_io_o,
  input logic [CNT_W-1:0]  q_count
);
  // R4
  queue_bound_chk: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(DEPTH));

  // R6
  port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_io_o)));

  // R7
  data_first_chk: assert property (@(posedge clk) disable iff (rst)
    (dreq_valid_i && !mem_req_o) |=> (mem_req_o && mem_addr_o == $past(dreq_addr_i)));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !out_valid_o);

  // R10
  done_owner_chk: assert property (@(posedge clk) disable iff (rst)
    dreq_done_o |-> (dreq_valid_i && mem_req_o && mem_ack_i));
endmodule

bind ifq_prefetch ifq_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .flush_i      (flush_i),
  .out_valid_o  (out_valid_o),
  .dreq_valid_i (dreq_valid_i),
  .dreq_addr_i  (dreq_addr_i),
  .dreq_done_o  (dreq_done_o),
  .mem_req_o    (mem_req_o),
  .mem_ack_i    (mem_ack_i),
  .mem_addr_o   (mem_addr_o),
  .mem_we_o     (mem_we_o),
  .mem_io_o     (mem_io_o),
  .q_count      (q_count)
);

// File: tb/ifq_prefetch_test.sv
`timescale 1ns/1ps
module ifq_prefetch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_i = 1'b0;
  logic [15:0] flush_seg_i = '0, flush_off_i = '0;
  logic        out_valid_o, out_ready_i = 1'b0;
  logic [7:0]  out_byte_o;
  logic        dreq_valid_i = 1'b0, dreq_write_i = 1'b0, dreq_io_i = 1'b0;
  logic [19:0] dreq_addr_i = '0;
  logic [7:0]  dreq_wdata_i = '0;
  logic        dreq_done_o;
  logic [7:0]  dreq_rdata_o;
  logic        mem_req_o, mem_we_o, mem_io_o;
  logic [19:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;

  int checks = 0, fails = 0, cyc = 0;
  int lat = 0, wcnt = 0, acks = 0;
  logic [19:0] held_addr = '0, last_addr = '0, prev_addr = '0;
  logic        last_we = 1'b0, last_io = 1'b0;
  logic [7:0]  last_wdata = '0;
  logic [15:0] exp_seg = '0, exp_off = '0;

  typedef struct packed {
    logic [15:0] seg;
    logic [15:0] off;
    logic [3:0]  lat;
    logic        alt;
    logic [7:0]  n;
  } vec_t;

  // R2 (20-bit wrap in entry 2), R3 (offset wrap in entries 1 and 5)
  localparam vec_t VECS [6] = '{
    '{16'h1234, 16'h0010, 4'd0, 1'b0, 8'd8},
    '{16'hF000, 16'hFFFE, 4'd1, 1'b0, 8'd5},
    '{16'hFFFF, 16'h0020, 4'd2, 1'b1, 8'd7},
    '{16'h0800, 16'h7FFF, 4'd0, 1'b1, 8'd9},
    '{16'hABCD, 16'h1234, 4'd5, 1'b0, 8'd4},
    '{16'h0000, 16'hFFFF, 4'd3, 1'b1, 8'd6}
  };

  always #2 clk = ~clk;

  ifq_prefetch uut (.*);

  function automatic logic [7:0] mv(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return 20'({s, 4'h0}) + 20'(o);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  // memory model: acknowledge after lat waiting cycles
  always @(negedge clk) begin
    if (rst) begin
      mem_ack_i = 1'b0; wcnt = 0; acks = 0;
    end else if (mem_ack_i) begin
      mem_ack_i = 1'b0; wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt == 0) held_addr = mem_addr_o;
      else if (mem_addr_o != held_addr) begin
        checks++; fails++;
        $display("FAIL R6 hold: actual %h expected %h", mem_addr_o, held_addr);
      end
      if (wcnt >= lat) begin
        mem_ack_i   = 1'b1;
        mem_rdata_i = mv(mem_addr_o);
        prev_addr   = last_addr;
        last_addr   = mem_addr_o;
        last_we     = mem_we_o;
        last_io     = mem_io_o;
        last_wdata  = mem_wdata_o;
        acks++;
      end else wcnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic consume(input int n, input bit alt);
    int got = 0;
    int guard = 0;
    bit ph = 1'b0;
    while (got < n && guard < 2000) begin
      tick();
      guard++;
      ph = ~ph;
      out_ready_i = alt ? ph : 1'b1;
      if (out_valid_o && out_ready_i) begin
        chk(out_byte_o == mv(phys(exp_seg, exp_off)), "R5 order R2/R3 address",
            {24'h0, out_byte_o}, {24'h0, mv(phys(exp_seg, exp_off))});
        exp_off++;
        got++;
      end
    end
    if (got < n) chk(1'b0, "R5 stall", got, n);
    tick();
    out_ready_i = 1'b0;
  endtask

  task automatic flush_to(input logic [15:0] s, input logic [15:0] o, input bit rdy);
    tick();
    flush_i = 1'b1; flush_seg_i = s; flush_off_i = o;
    out_ready_i = rdy;  // handshake in the flush cycle must be ignored (R9)
    tick();
    flush_i = 1'b0; out_ready_i = 1'b0;
    chk(!out_valid_o, "R9 empty", out_valid_o, 0);
    exp_seg = s; exp_off = o;
  endtask

  initial begin
    int guard;
    repeat (4) tick();
    // R1 reset state
    chk(!mem_req_o && !out_valid_o, "R1 reset", {mem_req_o, out_valid_o}, 0);
    rst = 1'b0;
    tick();
    chk(mem_req_o && !mem_we_o && !mem_io_o && mem_addr_o == 20'h0, "R1 first fetch",
        {mem_req_o, mem_addr_o}, {1'b1, 20'h0});

    // R4 capacity with no consumer
    repeat (40) tick();
    chk(acks == 6, "R4 six fetched", acks, 6);
    chk(!mem_req_o && out_valid_o, "R4 stalled", {mem_req_o, out_valid_o}, 2'b01);

    // R7 idle grant and R10 write forwarding
    dreq_valid_i = 1'b1; dreq_write_i = 1'b1; dreq_io_i = 1'b0;
    dreq_addr_i = 20'h5A5A5; dreq_wdata_i = 8'hC3;
    tick();
    chk(mem_req_o && mem_we_o && mem_addr_o == 20'h5A5A5 && mem_wdata_o == 8'hC3,
        "R7 idle grant", mem_addr_o, 20'h5A5A5);
    guard = 0;
    while (!dreq_done_o && guard < 100) begin tick(); guard++; end
    chk(dreq_done_o && last_we && !last_io && last_wdata == 8'hC3, "R10 write",
        {last_we, last_io, last_wdata}, {2'b10, 8'hC3});
    tick();
    dreq_valid_i = 1'b0; dreq_write_i = 1'b0;
    chk(!mem_req_o, "R4 still full", mem_req_o, 0);

    // R4 one byte out lets one fetch in
    exp_seg = 16'h0; exp_off = 16'h0;
    consume(1, 1'b0);
    repeat (20) tick();
    chk(acks == 8, "R4 one refill", acks, 8);
    chk(!mem_req_o, "R4 idle again", mem_req_o, 0);

    // vector table
    for (int i = 0; i < 6; i++) begin
      lat = int'(VECS[i].lat);
      flush_to(VECS[i].seg, VECS[i].off, VECS[i].alt);
      consume(int'(VECS[i].n), VECS[i].alt);
    end

    // R7/R8: data request while a slow fetch is in flight
    lat = 3;
    repeat (40) tick();
    flush_to(16'h2000, 16'h0100, 1'b0);
    tick();
    chk(mem_req_o && !mem_we_o && mem_addr_o == phys(16'h2000, 16'h0100), "R9 new address",
        mem_addr_o, phys(16'h2000, 16'h0100));
    dreq_valid_i = 1'b1; dreq_write_i = 1'b0; dreq_io_i = 1'b1; dreq_addr_i = 20'h00042;
    guard = 0;
    while (!dreq_done_o && guard < 100) begin tick(); guard++; end
    chk(dreq_rdata_o == mv(20'h00042), "R10 read data", dreq_rdata_o, mv(20'h00042));
    chk(last_io && last_addr == 20'h00042, "R10 io flag", {last_io, last_addr}, {1'b1, 20'h00042});
    chk(prev_addr == phys(16'h2000, 16'h0100), "R7 fetch finishes first",
        prev_addr, phys(16'h2000, 16'h0100));
    tick();
    dreq_valid_i = 1'b0; dreq_io_i = 1'b0;
    chk(mem_req_o && !mem_we_o && mem_addr_o == phys(16'h2000, 16'h0101), "R8 resume",
        mem_addr_o, phys(16'h2000, 16'h0101));
    consume(3, 1'b0);

    // R9: flush while a fetch is outstanding discards its byte
    lat = 6;
    repeat (40) tick();
    flush_to(16'h3000, 16'h0000, 1'b0);
    tick();
    tick();
    chk(mem_req_o && !mem_ack_i, "R9 fetch pending", {mem_req_o, mem_ack_i}, 2'b10);
    flush_to(16'h4000, 16'h0200, 1'b1);
    consume(4, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule